// File: doc/BRIEF.md
# Indexed Host Register Port with Transmit Buffer

This block is the host-facing control side of a small Ethernet MAC. A processor reaches it through a 16-bit bus that has two ports. An access to the address port (`host_sel_data` low) selects an 8-bit register index. Each access to the data port (`host_sel_data` high) then reads or writes the register at that index. The block holds the network control and status registers, the transmit control register, the frame length registers, the interrupt status and mask registers, and the buffer pointers. Read data is registered and appears on `host_rdata` one clock after the read strobe.

The host fills a 3072-byte transmit buffer through an auto-incrementing 16-bit write port. It then sets the transmit request bit. A small state machine streams the stored bytes out on a byte interface with valid, ready and last. It moves through these states:
- ST_IDLE goes to ST_FETCH on start, or straight to ST_FINISH when the length is zero.
- ST_FETCH goes to ST_SEND after one buffer read cycle.
- ST_SEND stays in ST_SEND while the byte stays in the same stored word. It goes to ST_FETCH when the pointer crosses into a new word, and to ST_FINISH after the final byte.
- ST_FINISH returns to ST_IDLE and signals completion.

A soft reset forces the state machine to ST_IDLE. Completions alternate between two done flags, and the interrupt line follows status ANDed with mask.

Top module: `hostreg_port`

## Requirements
- R1: A write on the address port latches bits 7:0 as the register index. A read on the address port returns that index in bits 7:0 with bits 15:8 zero. Read data appears on `host_rdata` one clock after the read strobe, and register reads return the value in bits 7:0.
- R2: Fixed identity reads are 0x46 at index 0x28, 0x0A at 0x29, 0x00 at 0x2A and 0x90 at 0x2B. Indexes 0x03 and 0x04 always read 0.
- R3: A data write at index 0xF8 stores the word at the buffer write pointer, with bits 7:0 at the even byte and bits 15:8 at the next byte, and then advances the pointer by 2. Index 0xF6 stores the word the same way without advancing. The pointer reads back at 0xFA (low) and 0xFB (high).
- R4: With interrupt-mask bit 7 clear, the write pointer stays unchanged when advancing would reach 3072. With bit 7 set, it wraps modulo 3072.
- R5: Writing bit 0 of index 0x02 starts a frame. The frame has min(length, 3072) bytes, where length comes from 0xFC (low) and 0xFD (high). The bytes are read from the buffer starting at the transmit read pointer, wrapping modulo 3072. `tx_last` is high with the final byte only, and a byte holds while `tx_ready` is low.
- R6: On completion, bit 0 of index 0x02 clears. Bit 2 of index 0x01 is set for even-numbered frames and bit 3 for odd ones (the packet index starts at 0 and toggles). Interrupt status bit 1 is set. The transmit read pointer (0x22 low, 0x23 high) becomes the end position rounded up to even.
- R7: Reading index 0x01 returns its value and then clears bits 2 and 3. A data write to 0x01 clears those of bits 2, 3 and 5 written as 1. Bit 6 (link) reads 1 after reset.
- R8: A data write to index 0xFE clears the status bits among 3:0 that are written as 1. `irq` is high exactly when (status AND mask AND 0x03) is nonzero, where the mask is index 0xFF.
- R9: A data write to index 0x00 with bit 0 set is a soft reset. The write pointer and transmit read pointer go to 0, the receive read pointer goes to 0x0C00, and mask and interrupt status go to 0. Index 0x00 becomes (written value AND 0xA0) OR 0x08. Index 0x01 becomes (old AND 0xD0) OR 0x40. Any frame in flight is dropped.
- R10: When mask bit 7 goes from 0 to 1, the high byte of the receive read pointer (0xF5, low byte at 0xF4, both writable) is forced to 0x0C. Rewriting the mask with bit 7 already set leaves it alone.
- R11: While a frame is in flight, register accesses proceed, but a further transmit request is ignored, and exactly one completion results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_sel_data | input | 1 | 0 selects the address port, 1 selects the data port |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request, active high |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
Frames are sent with different lengths and alignments:
- A 5-byte frame under periodic backpressure checks byte order, holding and the odd-end rounding.
- A 3-byte and a 2-byte frame check that the done flags alternate.
- A 100-byte frame with a repeated request while it is in flight shows whether requests are dropped or doubled.
- An oversized length shows the cap at 3072 and the wrap of the read pointer.

Filling the whole buffer with mask bit 7 clear and then set separates the saturating write pointer from the wrapping one. Soft reset is issued with a done flag pending, so that the kept and cleared status bits can be told apart.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_FINISH
    } tx_state_e;

    // Register indexes decoded by the host port
    localparam logic [7:0] IX_NETCTL  = 8'h00;
    localparam logic [7:0] IX_NETSTAT = 8'h01;
    localparam logic [7:0] IX_TXCTL   = 8'h02;
    localparam logic [7:0] IX_TXST_A  = 8'h03;
    localparam logic [7:0] IX_TXST_B  = 8'h04;
    localparam logic [7:0] IX_TRP_LO  = 8'h22;
    localparam logic [7:0] IX_TRP_HI  = 8'h23;
    localparam logic [7:0] IX_ID_0    = 8'h28;
    localparam logic [7:0] IX_ID_1    = 8'h29;
    localparam logic [7:0] IX_ID_2    = 8'h2A;
    localparam logic [7:0] IX_ID_3    = 8'h2B;
    localparam logic [7:0] IX_RRP_LO  = 8'hF4;
    localparam logic [7:0] IX_RRP_HI  = 8'hF5;
    localparam logic [7:0] IX_WR_HOLD = 8'hF6;
    localparam logic [7:0] IX_WR_INC  = 8'hF8;
    localparam logic [7:0] IX_WWP_LO  = 8'hFA;
    localparam logic [7:0] IX_WWP_HI  = 8'hFB;
    localparam logic [7:0] IX_LEN_LO  = 8'hFC;
    localparam logic [7:0] IX_LEN_HI  = 8'hFD;
    localparam logic [7:0] IX_ISTAT   = 8'hFE;
    localparam logic [7:0] IX_IMASK   = 8'hFF;

endpackage

// File: rtl/hrp_txbuf.sv
module hrp_txbuf #(
    parameter int WORDS = 1536,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);

    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/hrp_txstream.sv
module hrp_txstream #(
    parameter int BUF_BYTES = 3072,
    parameter int LEN_W     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          start,
    input  logic [$clog2(BUF_BYTES)-1:0] base_ptr,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [15:0]   rd_word,
    output logic [$clog2(BUF_BYTES)-2:0] rd_addr,
    output logic          busy,
    output logic          done,
    output logic [$clog2(BUF_BYTES)-1:0] end_ptr,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    output logic          tx_last,
    input  logic          tx_ready
);
    import hrp_pkg::*;

    localparam int PW = $clog2(BUF_BYTES);
    localparam int CW = $clog2(BUF_BYTES + 1);

    tx_state_e     state_q, state_d;
    logic [PW-1:0] ptr_q, ptr_d, ptr_inc;
    logic [CW-1:0] remain_q, remain_d, capped;

    assign ptr_inc = (ptr_q == PW'(BUF_BYTES - 1)) ? '0 : ptr_q + 1'b1;
    assign capped  = (frame_len > LEN_W'(BUF_BYTES)) ? CW'(BUF_BYTES)
                                                     : frame_len[CW-1:0];

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        ptr_d    = ptr_q;
        remain_d = remain_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ptr_d    = base_ptr;
                    remain_d = capped;
                    state_d  = (capped == '0) ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FETCH: begin
                state_d = ST_SEND;
            end
            ST_SEND: begin
                if (tx_ready) begin
                    ptr_d    = ptr_inc;
                    remain_d = remain_q - 1'b1;
                    if (remain_q == CW'(1)) begin
                        state_d = ST_FINISH;
                    end else if (!ptr_inc[0]) begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
        if (soft_rst) begin
            state_d = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ptr_q    <= '0;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            ptr_q    <= ptr_d;
            remain_q <= remain_d;
        end
    end

    // Outputs
    always_comb begin
        rd_addr  = ptr_q[PW-1:1];
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FINISH);
        end_ptr  = ptr_q[0] ? ptr_inc : ptr_q;
        tx_valid = (state_q == ST_SEND);
        tx_data  = ptr_q[0] ? rd_word[15:8] : rd_word[7:0];
        tx_last  = tx_valid && (remain_q == CW'(1));
    end

    // R5: last only accompanies a valid byte
    a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R5: a stalled byte stays offered with the same last marker
    a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !soft_rst) |=> (tx_valid && $stable(tx_last)));

    // R11: the host side only issues start while the stream is idle
    a_r11_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == ST_IDLE));

endmodule

// File: rtl/hostreg_port.sv
module hostreg_port #(
    parameter int BUF_BYTES = 3072
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_sel_data,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        irq,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready
);
    import hrp_pkg::*;

    localparam int PW    = $clog2(BUF_BYTES);
    localparam int WORDS = BUF_BYTES / 2;
    localparam int LEN_W = 16;
    localparam logic [15:0] RX_BASE = 16'(BUF_BYTES);
    localparam logic [PW:0] BUF_END = (PW+1)'(BUF_BYTES);

    logic [7:0]  idx_q, idx_d;
    logic [7:0]  ncr_q, ncr_d, nsr_q, nsr_d, tcr_q, tcr_d;
    logic [7:0]  isr_q, isr_d, imr_q, imr_d;
    logic [15:0] len_q, len_d, mrr_q, mrr_d;
    logic [PW-1:0] mwr_q, mwr_d, trp_q, trp_d;
    logic        pkt_q, pkt_d;
    logic [15:0] rdata_q;
    logic [7:0]  rd_val;

    logic awr, ard, dwr, drd, soft_rst, start, mem_we;
    logic [PW:0]   mwr_step;
    logic [PW-1:0] mwr_adv;

    logic          busy, tx_done;
    logic [PW-1:0] end_ptr;
    logic [PW-2:0] buf_raddr;
    logic [15:0]   buf_rword;

    assign awr = host_wr && !host_sel_data;
    assign ard = host_rd && !host_sel_data;
    assign dwr = host_wr && host_sel_data;
    assign drd = host_rd && host_sel_data;

    assign soft_rst = dwr && (idx_q == IX_NETCTL) && host_wdata[0];
    assign start    = dwr && (idx_q == IX_TXCTL) && host_wdata[0] && !busy && !soft_rst;
    assign mem_we   = dwr && ((idx_q == IX_WR_INC) || (idx_q == IX_WR_HOLD));

    // Write pointer advance: wrap or saturate by mask bit 7
    assign mwr_step = {1'b0, mwr_q} + (PW+1)'(2);
    always_comb begin
        if (imr_q[7]) begin
            mwr_adv = (mwr_step >= BUF_END) ? PW'(mwr_step - BUF_END) : mwr_step[PW-1:0];
        end else begin
            mwr_adv = (mwr_step < BUF_END) ? mwr_step[PW-1:0] : mwr_q;
        end
    end

    // Read multiplexer
    always_comb begin
        case (idx_q)
            IX_NETCTL:  rd_val = ncr_q;
            IX_NETSTAT: rd_val = nsr_q;
            IX_TXCTL:   rd_val = tcr_q;
            IX_TXST_A:  rd_val = 8'h00;
            IX_TXST_B:  rd_val = 8'h00;
            IX_TRP_LO:  rd_val = 8'(16'(trp_q));
            IX_TRP_HI:  rd_val = 8'(16'(trp_q) >> 8);
            IX_ID_0:    rd_val = 8'h46;
            IX_ID_1:    rd_val = 8'h0A;
            IX_ID_2:    rd_val = 8'h00;
            IX_ID_3:    rd_val = 8'h90;
            IX_RRP_LO:  rd_val = mrr_q[7:0];
            IX_RRP_HI:  rd_val = mrr_q[15:8];
            IX_WWP_LO:  rd_val = 8'(16'(mwr_q));
            IX_WWP_HI:  rd_val = 8'(16'(mwr_q) >> 8);
            IX_LEN_LO:  rd_val = len_q[7:0];
            IX_LEN_HI:  rd_val = len_q[15:8];
            IX_ISTAT:   rd_val = isr_q;
            IX_IMASK:   rd_val = imr_q;
            default:    rd_val = 8'h00;
        endcase
    end

    // Register next values
    always_comb begin
        idx_d = idx_q;
        ncr_d = ncr_q;
        nsr_d = nsr_q;
        tcr_d = tcr_q;
        isr_d = isr_q;
        imr_d = imr_q;
        len_d = len_q;
        mrr_d = mrr_q;
        mwr_d = mwr_q;
        trp_d = trp_q;
        pkt_d = pkt_q;

        if (awr) begin
            idx_d = host_wdata[7:0];
        end
        if (dwr) begin
            case (idx_q)
                IX_NETCTL:  ncr_d = host_wdata[7:0] & 8'hDF;
                IX_NETSTAT: nsr_d = nsr_q & ~(host_wdata[7:0] & 8'h2C);
                IX_TXCTL:   tcr_d = {host_wdata[7:1], busy ? tcr_q[0] : host_wdata[0]};
                IX_RRP_LO:  mrr_d[7:0]  = host_wdata[7:0];
                IX_RRP_HI:  mrr_d[15:8] = host_wdata[7:0];
                IX_WR_INC:  mwr_d = mwr_adv;
                IX_LEN_LO:  len_d[7:0]  = host_wdata[7:0];
                IX_LEN_HI:  len_d[15:8] = host_wdata[7:0];
                IX_ISTAT:   isr_d = isr_q & ~(host_wdata[7:0] & 8'h0F);
                IX_IMASK: begin
                    imr_d = host_wdata[7:0];
                    if (!imr_q[7] && host_wdata[7]) begin
                        mrr_d[15:8] = RX_BASE[15:8];
                    end
                end
                default: ;
            endcase
        end
        if (drd && (idx_q == IX_NETSTAT)) begin
            nsr_d[3:2] = 2'b00;
        end
        if (tx_done) begin
            tcr_d[0] = 1'b0;
            if (pkt_q) begin
                nsr_d[3] = 1'b1;
            end else begin
                nsr_d[2] = 1'b1;
            end
            isr_d[1] = 1'b1;
            pkt_d    = ~pkt_q;
            trp_d    = end_ptr;
        end
        if (soft_rst) begin
            ncr_d = (host_wdata[7:0] & 8'hA0) | 8'h08;
            nsr_d = (nsr_q & 8'hD0) | 8'h40;
            tcr_d = 8'h00;
            isr_d = 8'h00;
            imr_d = 8'h00;
            len_d = 16'h0000;
            mrr_d = RX_BASE;
            mwr_d = '0;
            trp_d = '0;
            pkt_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= 8'h00;
            ncr_q   <= 8'h08;
            nsr_q   <= 8'h40;
            tcr_q   <= 8'h00;
            isr_q   <= 8'h00;
            imr_q   <= 8'h00;
            len_q   <= 16'h0000;
            mrr_q   <= RX_BASE;
            mwr_q   <= '0;
            trp_q   <= '0;
            pkt_q   <= 1'b0;
            rdata_q <= 16'h0000;
        end else begin
            idx_q <= idx_d;
            ncr_q <= ncr_d;
            nsr_q <= nsr_d;
            tcr_q <= tcr_d;
            isr_q <= isr_d;
            imr_q <= imr_d;
            len_q <= len_d;
            mrr_q <= mrr_d;
            mwr_q <= mwr_d;
            trp_q <= trp_d;
            pkt_q <= pkt_d;
            if (ard) begin
                rdata_q <= {8'h00, idx_q};
            end else if (drd) begin
                rdata_q <= {8'h00, rd_val};
            end
        end
    end

    assign host_rdata = rdata_q;
    assign irq        = |(isr_q & imr_q & 8'h03);

    hrp_txbuf #(
        .WORDS (WORDS),
        .AW    (PW - 1)
    ) u_buf (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mwr_q[PW-1:1]),
        .wdata (host_wdata),
        .raddr (buf_raddr),
        .rdata (buf_rword)
    );

    hrp_txstream #(
        .BUF_BYTES (BUF_BYTES),
        .LEN_W     (LEN_W)
    ) u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .start     (start),
        .base_ptr  (trp_q),
        .frame_len (len_q),
        .rd_word   (buf_rword),
        .rd_addr   (buf_raddr),
        .busy      (busy),
        .done      (tx_done),
        .end_ptr   (end_ptr),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready)
    );

    // R4: the write pointer stays even and inside the buffer
    a_r4_wptr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_q < PW'(BUF_BYTES)) && !mwr_q[0]);

    // R6: completion drops the transmit request bit
    a_r6_done_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !soft_rst) |=> !tcr_q[0]);

    // R6: completion flips the packet index
    a_r6_index_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !soft_rst) |=> (pkt_q != $past(pkt_q)));

    // R8: the interrupt only rises after a completion or a mask write
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tx_done || (dwr && (idx_q == IX_IMASK))));

    // R9: soft reset leaves pointers, mask, status and the stream cleared
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((mwr_q == '0) && (trp_q == '0) && (imr_q == 8'h00)
                      && (isr_q == 8'h00) && !tx_valid));

endmodule

// File: tb/hostreg_port_bench.sv
module hostreg_port_bench;

    localparam int BUF = 3072;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_sel_data = 1'b0;
    logic [15:0] host_wdata = 16'h0000;
    logic [15:0] host_rdata;
    logic        irq;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_last;
    logic        tx_ready = 1'b1;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [7:0] model [BUF];
    int  b_mwr = 0;
    bit  b_wrap = 0;

    always #10 clk = ~clk;

    hostreg_port u_hostreg_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .host_sel_data (host_sel_data),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .irq           (irq),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_last       (tx_last),
        .tx_ready      (tx_ready)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ 8'h5C);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic addr_wr(input logic [7:0] ix);
        @(negedge clk);
        host_wr = 1'b1; host_sel_data = 1'b0; host_wdata = {8'h00, ix};
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic data_wr(input logic [15:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_sel_data = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic data_rd(output logic [15:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_sel_data = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic addr_rd(output logic [15:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_sel_data = 1'b0;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic wr_reg(input logic [7:0] ix, input logic [7:0] v);
        addr_wr(ix);
        data_wr({8'h00, v});
    endtask

    task automatic rd_reg(input logic [7:0] ix, output logic [15:0] v);
        addr_wr(ix);
        data_rd(v);
    endtask

    // Data write at the current index (0xF8 or 0xF6), mirrored in the model
    task automatic push_word(input logic [15:0] w, input bit inc);
        int step;
        data_wr(w);
        model[b_mwr]     = w[7:0];
        model[b_mwr + 1] = w[15:8];
        if (inc) begin
            step = b_mwr + 2;
            if (b_wrap) b_mwr = (step >= BUF) ? step - BUF : step;
            else if (step < BUF) b_mwr = step;
        end
    endtask

    task automatic check_ptr(input string req, input logic [7:0] lo_ix, input int exp);
        logic [15:0] lo, hi;
        rd_reg(lo_ix, lo);
        rd_reg(lo_ix + 8'h01, hi);
        check(req, "pointer", {16'h0, hi[7:0], lo[7:0]}, 32'(exp));
    endtask

    task automatic set_len(input int n);
        wr_reg(8'hFC, 8'(n));
        wr_reg(8'hFD, 8'(n >> 8));
    endtask

    task automatic collect(input string req, input int start, input int n, input bit stall);
        int got = 0;
        int cyc = 0;
        int errs = 0;
        int extra = 0;
        bit last_bad = 0;
        while (got < n && cyc < 8000) begin
            @(negedge clk);
            cyc++;
            tx_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            #1;
            if (tx_valid && tx_ready) begin
                if (tx_data !== model[(start + got) % BUF]) errs++;
                if (tx_last !== (got == n - 1)) last_bad = 1;
                got++;
            end
        end
        check(req, "byte count", got, n);
        check(req, "byte mismatches", errs, 0);
        check(req, "last marker", last_bad, 0);
        tx_ready = 1'b1;
        repeat (6) begin
            @(negedge clk);
            #1;
            if (tx_valid) extra++;
        end
        check(req, "extra bytes", extra, 0);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1", "reset rdata", host_rdata, 0);
        check("R8", "reset irq", irq, 0);
        check("R5", "reset tx_valid", tx_valid, 0);
        addr_rd(v);
        check("R1", "reset index", v, 16'h0000);
        rd_reg(8'h00, v);
        check("R9", "reset netctl", v, 16'h0008);
        rd_reg(8'h01, v);
        check("R7", "reset netstat link", v, 16'h0040);
        check_ptr("R10", 8'hF4, 16'h0C00);
        check_ptr("R6", 8'h22, 0);
    endtask

    task automatic t_index;
        logic [15:0] v;
        addr_wr(8'h5A);
        addr_rd(v);
        check("R1", "index readback", v, 16'h005A);
        addr_wr(8'hC3);
        addr_rd(v);
        check("R1", "index readback 2", v, 16'h00C3);
    endtask

    task automatic t_ident;
        logic [15:0] v;
        rd_reg(8'h28, v); check("R2", "id 0x28", v, 16'h0046);
        rd_reg(8'h29, v); check("R2", "id 0x29", v, 16'h000A);
        rd_reg(8'h2A, v); check("R2", "id 0x2A", v, 16'h0000);
        rd_reg(8'h2B, v); check("R2", "id 0x2B", v, 16'h0090);
        rd_reg(8'h03, v); check("R2", "txstat 0x03", v, 16'h0000);
        rd_reg(8'h04, v); check("R2", "txstat 0x04", v, 16'h0000);
    endtask

    task automatic t_write_port;
        addr_wr(8'hF8);
        for (int k = 0; k < 60; k++) push_word({pat(2*k+1), pat(2*k)}, 1'b1);
        check_ptr("R3", 8'hFA, 120);
        addr_wr(8'hF6);
        push_word(16'hDEAD, 1'b0);
        check_ptr("R3", 8'hFA, 120);
        addr_wr(8'hF8);
        push_word({pat(121), pat(120)}, 1'b1);
        check_ptr("R3", 8'hFA, 122);
    endtask

    task automatic t_tx_first;
        logic [15:0] v;
        wr_reg(8'hFF, 8'h02);
        set_len(5);
        tx_ready = 1'b1;
        wr_reg(8'h02, 8'h01);
        collect("R5", 0, 5, 1'b1);
        rd_reg(8'h02, v);
        check("R6", "request cleared", v, 16'h0000);
        check("R8", "irq after done", irq, 1);
        rd_reg(8'hFE, v);
        check("R6", "istat bit1", v, 16'h0002);
        check_ptr("R6", 8'h22, 6);
        rd_reg(8'h01, v);
        check("R6", "netstat done1", v, 16'h0044);
        rd_reg(8'h01, v);
        check("R7", "netstat cleared on read", v, 16'h0040);
    endtask

    task automatic t_tx_second;
        logic [15:0] v;
        set_len(3);
        wr_reg(8'h02, 8'h01);
        collect("R5", 6, 3, 1'b0);
        check_ptr("R6", 8'h22, 10);
        rd_reg(8'h01, v);
        check("R6", "netstat done2", v, 16'h0048);
        set_len(2);
        wr_reg(8'h02, 8'h01);
        collect("R5", 10, 2, 1'b0);
        check_ptr("R6", 8'h22, 12);
        wr_reg(8'h01, 8'h04);
        rd_reg(8'h01, v);
        check("R7", "netstat write clear", v, 16'h0040);
    endtask

    task automatic t_irq;
        logic [15:0] v;
        check("R8", "irq pending", irq, 1);
        wr_reg(8'hFF, 8'h00);
        check("R8", "irq masked", irq, 0);
        wr_reg(8'hFF, 8'h02);
        check("R8", "irq unmasked", irq, 1);
        wr_reg(8'hFE, 8'h02);
        check("R8", "irq after clear", irq, 0);
        rd_reg(8'hFE, v);
        check("R8", "istat cleared", v, 16'h0000);
    endtask

    task automatic t_busy;
        logic [15:0] v;
        set_len(100);
        tx_ready = 1'b0;
        wr_reg(8'h02, 8'h01);
        repeat (5) @(negedge clk);
        wr_reg(8'h02, 8'h01);
        rd_reg(8'h2B, v);
        check("R11", "access during frame", v, 16'h0090);
        collect("R11", 12, 100, 1'b1);
        repeat (10) @(negedge clk);
        check("R11", "no second frame", tx_valid, 0);
        check_ptr("R11", 8'h22, 112);
        rd_reg(8'h01, v);
        check("R11", "single completion", v, 16'h0048);
    endtask

    task automatic t_rx_ptr;
        logic [15:0] v;
        wr_reg(8'hF4, 8'h34);
        wr_reg(8'hF5, 8'h12);
        rd_reg(8'hF5, v);
        check("R10", "rrp high written", v, 16'h0012);
        wr_reg(8'hFF, 8'h80);
        b_wrap = 1;
        rd_reg(8'hF5, v);
        check("R10", "rrp high forced", v, 16'h000C);
        rd_reg(8'hF4, v);
        check("R10", "rrp low kept", v, 16'h0034);
        wr_reg(8'hF5, 8'h12);
        wr_reg(8'hFF, 8'h80);
        rd_reg(8'hF5, v);
        check("R10", "no force without rise", v, 16'h0012);
    endtask

    task automatic t_soft;
        logic [15:0] v;
        set_len(1);
        wr_reg(8'h02, 8'h01);
        collect("R5", 112, 1, 1'b0);
        check_ptr("R6", 8'h22, 114);
        wr_reg(8'h00, 8'hA1);
        b_mwr = 0;
        b_wrap = 0;
        rd_reg(8'h00, v);
        check("R9", "netctl after soft", v, 16'h00A8);
        rd_reg(8'h01, v);
        check("R9", "netstat after soft", v, 16'h0040);
        check_ptr("R9", 8'hFA, 0);
        check_ptr("R9", 8'h22, 0);
        check_ptr("R9", 8'hF4, 16'h0C00);
        rd_reg(8'hFF, v);
        check("R9", "mask after soft", v, 16'h0000);
        rd_reg(8'hFE, v);
        check("R9", "istat after soft", v, 16'h0000);
        check("R9", "irq after soft", irq, 0);
    endtask

    task automatic t_saturate;
        addr_wr(8'hF8);
        for (int k = 0; k < BUF / 2; k++) push_word({pat(2*k+1), pat(2*k)}, 1'b1);
        push_word({pat(BUF-1), pat(BUF-2)}, 1'b1);
        check_ptr("R4", 8'hFA, BUF - 2);
        wr_reg(8'hFF, 8'h80);
        b_wrap = 1;
        addr_wr(8'hF8);
        push_word({pat(BUF-1), pat(BUF-2)}, 1'b1);
        check_ptr("R4", 8'hFA, 0);
    endtask

    task automatic t_cap;
        logic [15:0] v;
        set_len(4000);
        wr_reg(8'h02, 8'h01);
        collect("R5", 0, BUF, 1'b0);
        check_ptr("R5", 8'h22, 0);
        rd_reg(8'h01, v);
        check("R6", "netstat after cap frame", v, 16'h0044);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_index;
        t_ident;
        t_write_port;
        t_tx_first;
        t_tx_second;
        t_irq;
        t_busy;
        t_rx_ptr;
        t_soft;
        t_saturate;
        t_cap;
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog all-requirements act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule